// File: doc/BRIEF.md
# Per-Instruction Port Strobe Decoder

This block sits beside a fast microcontroller. Each instruction is fetched together with an extra 8-bit select byte. The block decodes that byte into strobes for peripherals that share one 8-bit I/O bus. One field of the byte picks a read port. The block drives that port's read strobe during the input half of the instruction. Another field picks either a write port or one bit of an 8-bit addressable control latch. The block acts on that choice during the output half. The read field and the write field are independent, so any read port can be paired with any write port in one instruction.

The instruction-boundary pulse serves two purposes. On its trailing edge the write field is captured and held for the whole instruction. While the pulse is high, the read decoder is forced off, so back-to-back reads from different ports each produce a fresh strobe edge. The direction strobe selects between the input and output halves. The bank-select input marks accesses to the right bank, where the RAM responds directly; while it is set, no port strobe is produced and no control bit changes.

Top module: `port_strobe_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, both strobe vectors read zero after that edge and `ctl_bits` reads all ones (its inactive level).
- R2: After an edge where `boundary` is 0, `out_phase` is 0, `bank_right` is 0 and `sel_byte[3]` is 1, `rd_stb` equals one-hot of `sel_byte[2:0]`. If `sel_byte[3]` is 0 or `out_phase` is 1, `rd_stb` is zero.
- R3: After any edge where `boundary` is 1, `rd_stb` is zero, so two consecutive reads are separated by at least one idle cycle.
- R4: The write field `sel_byte[7:4]` is captured at the first edge where `boundary` is 0 after an edge where it was 1. Later changes of `sel_byte` do not affect writes until the next capture.
- R5: After an edge where `out_phase` is 1, `bank_right` is 0 and the held bit 7 is 0, `wr_stb` equals one-hot of the held `[6:4]`. While `out_phase` is 0, `wr_stb` is zero.
- R6: When the held bit 7 is 1, `wr_stb` stays zero. On the first edge of an output phase (`out_phase` 1 after 0), `ctl_bits[held [6:4]]` takes `latch_din`, and the other bits keep their values.
- R7: After an edge where `bank_right` is 1, both strobe vectors are zero and `ctl_bits` is unchanged.
- R8: `rd_stb` and `wr_stb` each have at most one bit set.
- R9: `rd_stb` and `wr_stb` are never active in the same cycle.
- R10: From reset until the first write-field capture, no write strobe appears and no control bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_byte | input | 8 | Per-instruction port-select byte |
| boundary | input | 1 | Instruction-boundary pulse |
| out_phase | input | 1 | Direction strobe, 1 in the output half |
| bank_right | input | 1 | Right-bank (RAM) access marker |
| latch_din | input | 1 | Data bit for a control-latch update |
| rd_stb | output | 8 | One-hot read strobes, active high |
| wr_stb | output | 8 | One-hot write strobes, active high |
| ctl_bits | output | 8 | Addressable control outputs, reset to ones |

## Verification
The assertions place no constraint on the inputs. They check only properties that the decoder must keep for any input sequence. The properties are: at most one strobe set in each vector, no read and write strobe in the same cycle, silence during the boundary pulse and in the right bank, and a stable latch during right-bank access. The stimulus therefore mixes instruction-shaped sequences with fully random cycles, in which the boundary pulse, phase and bank may arrive in any order. Each output is compared every cycle against a bench model built from the requirements. Directed cases cover a disabled read, changing the select byte after capture, and writes before the first capture.

// File: rtl/pstb_pkg.sv
package pstb_pkg;

    localparam int IDX_W = 3;
    localparam int NPORT = 1 << IDX_W;
    localparam int SEL_W = 2 * IDX_W + 2;

    typedef enum logic {
        WR_STROBE = 1'b0,
        WR_LATCH  = 1'b1
    } wr_kind_e;

    // select byte layout, MSB first
    typedef struct packed {
        wr_kind_e         kind;
        logic [IDX_W-1:0] wr_idx;
        logic             rd_en;
        logic [IDX_W-1:0] rd_idx;
    } sel_t;

    // write field held for one instruction
    typedef struct packed {
        logic             valid;
        wr_kind_e         kind;
        logic [IDX_W-1:0] idx;
    } wr_hold_t;

    function automatic logic [NPORT-1:0] one_hot(input logic [IDX_W-1:0] i);
        logic [NPORT-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/pstb_capture.sv
module pstb_capture
    import pstb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     boundary,
    input  sel_t     sel,
    output wr_hold_t hold
);
    logic     bnd_q;
    logic     trail;
    wr_hold_t hold_q;

    assign trail = bnd_q && !boundary;

    always_ff @(posedge clk) begin
        if (rst) begin
            bnd_q  <= 1'b0;
            hold_q <= '{valid: 1'b0, kind: WR_STROBE, idx: '0};
        end else begin
            bnd_q <= boundary;
            if (trail) begin
                hold_q.valid <= 1'b1;
                hold_q.kind  <= sel.kind;
                hold_q.idx   <= sel.wr_idx;
            end
        end
    end

    assign hold = hold_q;
endmodule

// File: rtl/pstb_decode.sv
module pstb_decode
    import pstb_pkg::*;
#(
    parameter int N   = NPORT,
    parameter int AW  = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] idx,
    output logic [N-1:0]  stb
);
    logic [N-1:0] stb_q;

    for (genvar p = 0; p < N; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) stb_q[p] <= 1'b0;
            else     stb_q[p] <= en && (idx == AW'(p));
        end
    end

    assign stb = stb_q;
endmodule

// File: rtl/pstb_ctl_latch.sv
module pstb_ctl_latch
    import pstb_pkg::*;
#(
    parameter int N  = NPORT,
    parameter int AW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [AW-1:0] addr,
    input  logic          din,
    output logic [N-1:0]  bits
);
    logic [N-1:0] bits_q;

    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                          bits_q[b] <= 1'b1;
            else if (upd && addr == AW'(b))   bits_q[b] <= din;
        end
    end

    assign bits = bits_q;
endmodule

// File: rtl/port_strobe_decoder.sv
module port_strobe_decoder
    import pstb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_byte,
    input  logic             boundary,
    input  logic             out_phase,
    input  logic             bank_right,
    input  logic             latch_din,
    output logic [NPORT-1:0] rd_stb,
    output logic [NPORT-1:0] wr_stb,
    output logic [NPORT-1:0] ctl_bits
);
    sel_t     sel;
    wr_hold_t hold;
    logic     out_q;
    logic     left_bank;
    logic     rd_en;
    logic     wr_en;
    logic     ctl_upd;

    assign sel       = sel_t'(sel_byte);
    assign left_bank = !bank_right;

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= out_phase;
    end

    pstb_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .sel      (sel),
        .hold     (hold)
    );

    // input half only, killed by the boundary pulse
    assign rd_en = left_bank && !out_phase && !boundary && sel.rd_en;

    // output half, strobe kind only
    assign wr_en = left_bank && out_phase && hold.valid && (hold.kind == WR_STROBE);

    // one latch update per output half
    assign ctl_upd = left_bank && out_phase && !out_q && hold.valid
                     && (hold.kind == WR_LATCH);

    pstb_decode #(.N(NPORT), .AW(IDX_W)) u_rd_dec (
        .clk (clk),
        .rst (rst),
        .en  (rd_en),
        .idx (sel.rd_idx),
        .stb (rd_stb)
    );

    pstb_decode #(.N(NPORT), .AW(IDX_W)) u_wr_dec (
        .clk (clk),
        .rst (rst),
        .en  (wr_en),
        .idx (hold.idx),
        .stb (wr_stb)
    );

    pstb_ctl_latch #(.N(NPORT), .AW(IDX_W)) u_ctl (
        .clk  (clk),
        .rst  (rst),
        .upd  (ctl_upd),
        .addr (hold.idx),
        .din  (latch_din),
        .bits (ctl_bits)
    );
endmodule

// File: rtl/pstb_checker.sv
module pstb_checker
    import pstb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             boundary,
    input logic             out_phase,
    input logic             bank_right,
    input logic [NPORT-1:0] rd_stb,
    input logic [NPORT-1:0] wr_stb,
    input logic [NPORT-1:0] ctl_bits
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_stb == '0 && wr_stb == '0 && ctl_bits == '1));

    // R8
    rd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_stb));

    // R8
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));

    // R9
    no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(|rd_stb && |wr_stb));

    // R3
    boundary_kills_rd_chk: assert property (@(posedge clk) disable iff (rst)
        boundary |=> rd_stb == '0);

    // R2
    out_half_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
        out_phase |=> rd_stb == '0);

    // R5
    in_half_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
        !out_phase |=> wr_stb == '0);

    // R7
    right_bank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bank_right |=> (rd_stb == '0 && wr_stb == '0));

    // R7
    right_bank_ctl_stable_chk: assert property (@(posedge clk) disable iff (rst)
        bank_right |=> $stable(ctl_bits));
endmodule

bind port_strobe_decoder pstb_checker u_pstb_checker (
    .clk        (clk),
    .rst        (rst),
    .boundary   (boundary),
    .out_phase  (out_phase),
    .bank_right (bank_right),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .ctl_bits   (ctl_bits)
);

// File: tb/test_port_strobe_decoder.sv
`timescale 1ns/1ps
module test_port_strobe_decoder;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] sel_byte;
    logic       boundary;
    logic       out_phase;
    logic       bank_right;
    logic       latch_din;
    logic [7:0] rd_stb;
    logic [7:0] wr_stb;
    logic [7:0] ctl_bits;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model state
    logic       m_bq, m_oq, m_hv, m_hk;
    logic [2:0] m_hi;
    logic [7:0] m_ctl, e_rd, e_wr;

    always #5 clk = ~clk;

    port_strobe_decoder i_port_strobe_decoder (
        .clk        (clk),
        .rst        (rst),
        .sel_byte   (sel_byte),
        .boundary   (boundary),
        .out_phase  (out_phase),
        .bank_right (bank_right),
        .latch_din  (latch_din),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .ctl_bits   (ctl_bits)
    );

    function automatic logic [7:0] oh(input logic [2:0] i);
        return 8'd1 << i;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
        end
    endtask

    // one clock with given inputs, compare every output against the model
    task automatic step(input logic r, input logic [7:0] s, input logic b,
                        input logic o, input logic bk, input logic d,
                        input string wtag);
        string rtag, wt, ctag;
        @(negedge clk);
        rst = r; sel_byte = s; boundary = b; out_phase = o;
        bank_right = bk; latch_din = d;
        e_rd = (!r && !b && !o && !bk && s[3]) ? oh(s[2:0]) : 8'h00;
        e_wr = (!r && m_hv && o && !bk && !m_hk) ? oh(m_hi) : 8'h00;
        if (r) m_ctl = 8'hFF;
        else if (m_hv && m_hk && o && !m_oq && !bk) m_ctl[m_hi] = d;
        rtag = r ? "R1" : bk ? "R7" : b ? "R3" : "R2";
        wt   = (wtag != "") ? wtag : r ? "R1" : bk ? "R7" : !m_hv ? "R10" : m_hk ? "R6" : "R5";
        ctag = r ? "R1" : bk ? "R7" : !m_hv ? "R10" : "R6";
        if (r) m_hv = 1'b0;
        else if (m_bq && !b) begin
            m_hv = 1'b1; m_hk = s[7]; m_hi = s[6:4];
        end
        m_bq = r ? 1'b0 : b;
        m_oq = r ? 1'b0 : o;
        @(posedge clk);
        #2;
        check(rtag, rd_stb, e_rd);
        check(wt, wr_stb, e_wr);
        check(ctag, ctl_bits, m_ctl);
        check("R8", 8'($countones(rd_stb) > 1), 8'h00);
        check("R8", 8'($countones(wr_stb) > 1), 8'h00);
        check("R9", 8'((|rd_stb) && (|wr_stb)), 8'h00);
    endtask

    // instruction-shaped sequence
    task automatic instr(input logic [7:0] s, input logic bk, input logic d);
        step(1'b0, s, 1'b1, 1'b0, 1'b0, d, "");
        step(1'b0, s, 1'b0, 1'b0, bk, d, "");
        step(1'b0, s, 1'b0, 1'b0, bk, d, "");
        step(1'b0, s, 1'b0, 1'b1, bk, d, "");
        step(1'b0, s, 1'b0, 1'b1, bk, d, "");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; sel_byte = '0; boundary = 1'b0; out_phase = 1'b0;
        bank_right = 1'b0; latch_din = 1'b0;
        m_bq = 0; m_oq = 0; m_hv = 0; m_hk = 0; m_hi = 0; m_ctl = 8'hFF;
        // R1: reset state
        step(1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        // R10: output phase before any capture
        step(1'b0, 8'h0C, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        step(1'b0, 8'h8C, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
        step(1'b0, 8'h8C, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        // R2: reads, enabled and disabled
        instr(8'h2D, 1'b0, 1'b0);
        instr(8'h27, 1'b0, 1'b0);
        // R3: back-to-back reads from different ports
        instr(8'h0A, 1'b0, 1'b0);
        instr(8'h0B, 1'b0, 1'b0);
        // R4: select byte changes after capture
        step(1'b0, 8'h50, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 8'h50, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 8'h20, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
        step(1'b0, 8'hF0, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
        // R6: latch updates, low then high on several bits
        instr(8'hB0, 1'b0, 1'b0);
        instr(8'h80, 1'b0, 1'b0);
        instr(8'hF4, 1'b0, 1'b0);
        instr(8'hB0, 1'b0, 1'b1);
        // R7: right bank, strobes and latch
        instr(8'h9E, 1'b1, 1'b0);
        instr(8'h1E, 1'b1, 1'b0);
        // random instruction sequences
        for (int i = 0; i < 1500; i++)
            instr(8'($urandom), ($urandom % 5) == 0, 1'($urandom));
        // fully random cycles, with an occasional reset
        for (int i = 0; i < 4000; i++)
            step(($urandom % 97) == 0, 8'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 4) == 0, 1'($urandom), "");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule